// File: doc/BRIEF.md
# Timed-Unlock Sleep Detector-Disable Control Register

This block is one byte of a core's control register. Among its bits is a bit that, for one sleep only, switches off the brown-out detector. The CPU can set that bit only through a two-write unlock that has a time limit. The first write opens a short window. A second write inside that window sets the guarded bit. The guarded bit then stays active for a few cycles and clears itself. If the core asks to sleep during those cycles, the block latches a detector-disable output. That output stays high until a wake pulse arrives.

All other writable bits in the byte are plain storage with no timing rules. The CPU port has three signals: write enable, write data and read data. The sleep request and the wake pulse are plain control inputs. None of the pins carries a data stream, so the block has no valid/ready handshake and no back-pressure. A write is taken in every cycle that `wr_en` is high.

Bit map (fixed, because software decodes it):
- bit 6 is the guarded bit.
- bit 5 is the unlock enable.
- bit 4 is the pull-up disable.
- bits 1 and 0 are the vector-select bits.
- bits 7, 3 and 2 read as zero.

Top module: `bod_sleep_ctl`

## Requirements
- R1: After reset, `rd_data` reads 8'h00 and `det_off` is low.
- R2: Bits 7, 3 and 2 of `rd_data` always read zero, whatever value is written.
- R3: Bits 4, 1 and 0 are plain storage. A write stores `wr_data[4]`, `wr_data[1]` and `wr_data[0]`, and these read back from the next cycle on.
- R4: A write with bit 6 = 1 and bit 5 = 1 is an opening write. It opens the unlock window, and bit 5 then reads 1. Bit 6 does not become 1 from this write.
- R5: The window is open for 4 cycles, counted from the cycle after the opening write. A write with bit 6 = 1 and bit 5 = 0 that comes 1 to 4 cycles after the opening write sets bit 6. The same write clears bit 5.
- R6: A completing write that comes 5 or more cycles after the opening write leaves bit 6 at zero. Bit 5 reads zero once 4 cycles have passed with no completing write.
- R7: Any write during an open window that is neither a completing write nor an opening write closes the window at once. A later completing write is then ignored. A new opening write restarts the 4-cycle window.
- R8: Once set, bit 6 reads 1 for exactly 3 cycles and then clears by itself.
- R9: A write with bit 6 = 1 while no window is open leaves bit 6 unchanged. The other writable bits of that same write still update.
- R10: If `sleep_req` is high at a clock edge while bit 6 is active, `det_off` rises after that edge. A sleep request in the cycle after bit 6 clears leaves `det_off` low.
- R11: Once high, `det_off` stays high until `wake` is sampled high, and then drops at that edge. If `wake` and a qualifying sleep request arrive at the same edge, `wake` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Current register value |
| sleep_req | input | 1 | Sleep entry request from the core |
| wake | input | 1 | Wake event pulse |
| det_off | output | 1 | Brown-out detector disable for the current sleep |

## Verification
The bench places completing writes on both sides of the window edge: 4 cycles after the opening write, which must be accepted, and 5 cycles after, which must be rejected. A counter that is off by one fails one of these two checks. It also places a sleep request on the last active cycle of the guarded bit and another one cycle after the bit clears. A hold timer that is too long or too short, or a gate that samples the bit after it updates, fails one of these. Cancelling writes, guarded-bit writes with no window open, and wake pulses that overlap sleep requests expose a design that forgets to close the window, that lets software set the bit directly, or that gives the set priority over wake.

// File: rtl/bod_ctl_pkg.sv
package bod_ctl_pkg;
  localparam int unsigned BIT_GRD = 6;
  localparam int unsigned BIT_ENA = 5;
  localparam int unsigned BIT_PUD = 4;
  localparam int unsigned BIT_VS1 = 1;
  localparam int unsigned BIT_VS0 = 0;

  typedef enum logic [1:0] {
    WR_NONE     = 2'd0,
    WR_OPEN     = 2'd1,
    WR_COMPLETE = 2'd2,
    WR_OTHER    = 2'd3
  } wr_kind_e;
endpackage

// File: rtl/bod_unlock.sv
module bod_unlock
  import bod_ctl_pkg::*;
#(
  parameter int unsigned WIN_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wd_grd,
  input  logic wd_ena,
  output logic win_open,
  output logic complete
);
  localparam int unsigned CW = $clog2(WIN_CYC + 1);
  localparam logic [CW-1:0] WIN_LD = CW'(WIN_CYC);

  logic [CW-1:0] win_cnt;
  wr_kind_e      kind;

  always_comb begin
    if (!wr_en)                kind = WR_NONE;
    else if (wd_grd && wd_ena) kind = WR_OPEN;
    else if (wd_grd && win_open) kind = WR_COMPLETE;
    else                       kind = WR_OTHER;
  end

  assign win_open = (win_cnt != '0);
  assign complete = (kind == WR_COMPLETE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_cnt <= '0;
    end else begin
      unique case (kind)
        WR_OPEN:     win_cnt <= WIN_LD;
        WR_COMPLETE,
        WR_OTHER:    win_cnt <= '0;
        default:     if (win_open) win_cnt <= win_cnt - 1'b1;
      endcase
    end
  end

  p_open_sets_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wd_grd && wd_ena) |=> win_open);
  p_other_cancels_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wd_grd) |=> !win_open);
endmodule

// File: rtl/bod_hold.sv
module bod_hold #(
  parameter int unsigned HOLD_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic guard
);
  localparam int unsigned HW = $clog2(HOLD_CYC + 1);
  localparam logic [HW-1:0] HOLD_LD = HW'(HOLD_CYC);

  logic [HW-1:0] hold_cnt;

  assign guard = (hold_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)      hold_cnt <= '0;
    else if (load)   hold_cnt <= HOLD_LD;
    else if (guard)  hold_cnt <= hold_cnt - 1'b1;
  end

  generate
    if (HOLD_CYC >= 2) begin : g_len_chk
      p_guard_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(guard) |=> guard);
    end
  endgenerate
  p_load_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> guard);
endmodule

// File: rtl/bod_sleep_gate.sv
module bod_sleep_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic guard,
  input  logic sleep_req,
  input  logic wake,
  output logic det_off
);
  always_ff @(posedge clk) begin
    if (!rst_n)                   det_off <= 1'b0;
    else if (wake)                det_off <= 1'b0;
    else if (sleep_req && guard)  det_off <= 1'b1;
  end

  p_wake_drops_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !det_off);
  p_rise_needs_guard_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_off) |-> ($past(guard) && $past(sleep_req)));
  p_holds_until_wake_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (det_off && !wake) |=> det_off);
endmodule

// File: rtl/bod_sleep_ctl.sv
module bod_sleep_ctl
  import bod_ctl_pkg::*;
#(
  parameter int unsigned WIN_CYC  = 4,
  parameter int unsigned HOLD_CYC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       sleep_req,
  input  logic       wake,
  output logic       det_off
);
  logic win_open;
  logic complete;
  logic guard;
  logic pud_q;
  logic [1:0] vs_q;
  logic unused_bits;

  assign unused_bits = ^{wr_data[7], wr_data[3:2]};

  bod_unlock #(.WIN_CYC(WIN_CYC)) u_unlock (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wd_grd(wr_data[BIT_GRD]), .wd_ena(wr_data[BIT_ENA]),
    .win_open(win_open), .complete(complete)
  );

  bod_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(complete), .guard(guard)
  );

  bod_sleep_gate u_gate (
    .clk(clk), .rst_n(rst_n), .guard(guard),
    .sleep_req(sleep_req), .wake(wake), .det_off(det_off)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pud_q <= 1'b0;
      vs_q  <= 2'b00;
    end else if (wr_en) begin
      pud_q <= wr_data[BIT_PUD];
      vs_q  <= {wr_data[BIT_VS1], wr_data[BIT_VS0]};
    end
  end

  always_comb begin
    rd_data          = 8'h00;
    rd_data[BIT_GRD] = guard;
    rd_data[BIT_ENA] = win_open;
    rd_data[BIT_PUD] = pud_q;
    rd_data[BIT_VS1] = vs_q[1];
    rd_data[BIT_VS0] = vs_q[0];
  end

  p_guard_needs_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(guard) |-> ($past(wr_en) && $past(win_open)));
  p_window_closed_at_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(guard) |-> !rd_data[BIT_ENA]);
  p_no_window_no_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_open && !guard) |=> !guard);
  p_plain_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[BIT_PUD] == $past(wr_data[BIT_PUD])));
endmodule

// File: tb/tb_bod_sleep_ctl.sv
module tb_bod_sleep_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       sleep_req = 1'b0;
  logic       wake = 1'b0;
  logic       det_off;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  // reference model state
  int m_win = 0, m_hold = 0;
  bit m_det = 0, m_pud = 0;
  bit [1:0] m_vs = 0;

  always #4 clk = ~clk;

  bod_sleep_ctl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .sleep_req(sleep_req), .wake(wake), .det_off(det_off)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit [7:0] model_rd();
    return {1'b0, (m_hold > 0), (m_win > 0), m_pud, 2'b00, m_vs};
  endfunction

  // cycle-by-cycle reference, compared 2 ns after each edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_win = 0; m_hold = 0; m_det = 0; m_pud = 0; m_vs = 0;
    end else begin
      bit g_before;
      g_before = (m_hold > 0);
      if (wake) m_det = 0;
      else if (sleep_req && g_before) m_det = 1;
      if (m_hold > 0) m_hold--;
      if (wr_en) begin
        if (wr_data[6] && !wr_data[5] && m_win > 0) m_hold = 3;
        if (wr_data[6] && wr_data[5]) m_win = 4;
        else m_win = 0;
        m_pud = wr_data[4];
        m_vs  = wr_data[1:0];
      end else if (m_win > 0) begin
        m_win--;
      end
    end
    #2;
    if (rst_n && !done) begin
      check(rd_data[7] == 0 && rd_data[3:2] == 0, "R2 ro bits", rd_data, model_rd());
      check({rd_data[4], rd_data[1:0]} == {m_pud, m_vs}, "R3 plain bits", rd_data, model_rd());
      check(rd_data[5] == (m_win > 0), "R4 enable readback", rd_data, model_rd());
      check(rd_data[6] == (m_hold > 0), "R8 guarded bit", rd_data, model_rd());
      check(det_off == m_det, "R10 det_off", det_off, m_det);
    end
  end

  task automatic cyc(input bit we, input bit [7:0] wd, input bit slp, input bit wk);
    @(negedge clk);
    wr_en = we; wr_data = wd; sleep_req = slp; wake = wk;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 8'h00, 0, 0);
  endtask

  task automatic settle();
    @(posedge clk); #3;
  endtask

  initial begin
    #(8 * 200000);
    n_err++; n_chk++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    settle();
    check(rd_data == 8'h00 && det_off == 0, "R1 reset state", rd_data, 0);
    @(negedge clk); rst_n = 1'b1;

    // R2 / R3: plain and read-only bits
    cyc(1, 8'h9F, 0, 0); settle();
    check(rd_data == 8'h13, "R2 R3 write 9F", rd_data, 8'h13);
    idle(2);

    // R4 + R5: accepted on cycle 4
    cyc(1, 8'h60, 0, 0); settle();
    check(rd_data[6:5] == 2'b01, "R4 open write", rd_data[6:5], 1);
    idle(3);
    cyc(1, 8'h40, 0, 0); settle();
    check(rd_data[6:5] == 2'b10, "R5 completion at cycle 4", rd_data[6:5], 2);
    idle(5);

    // R6: rejected on cycle 5
    cyc(1, 8'h60, 0, 0);
    idle(4); settle();
    check(rd_data[5] == 0, "R6 window expired", rd_data[5], 0);
    cyc(1, 8'h40, 0, 0); settle();
    check(rd_data[6] == 0, "R6 completion at cycle 5", rd_data[6], 0);
    idle(2);

    // R7: cancel by another write
    cyc(1, 8'h60, 0, 0);
    cyc(1, 8'h10, 0, 0); settle();
    check(rd_data[5] == 0, "R7 cancel closes window", rd_data[5], 0);
    cyc(1, 8'h40, 0, 0); settle();
    check(rd_data[6] == 0, "R7 completion after cancel", rd_data[6], 0);
    // R7: reopening restarts the window
    cyc(1, 8'h60, 0, 0); idle(2);
    cyc(1, 8'h60, 0, 0); idle(3);
    cyc(1, 8'h40, 0, 0); settle();
    check(rd_data[6] == 1, "R7 restart window", rd_data[6], 1);
    idle(5);

    // R9: guarded bit write with no window
    cyc(1, 8'h51, 0, 0); settle();
    check(rd_data == 8'h11, "R9 ignored guard write", rd_data, 8'h11);
    idle(2);

    // R8 + R10 + R11: sleep on last active cycle
    cyc(1, 8'h60, 0, 0);
    cyc(1, 8'h40, 0, 0);
    idle(2); settle();
    check(rd_data[6] == 1, "R8 still active on third cycle", rd_data[6], 1);
    cyc(0, 8'h00, 1, 0); settle();
    check(det_off == 1, "R10 sleep in active window", det_off, 1);
    check(rd_data[6] == 0, "R8 auto clear", rd_data[6], 0);
    idle(5); settle();
    check(det_off == 1, "R11 hold until wake", det_off, 1);
    cyc(0, 8'h00, 0, 1); settle();
    check(det_off == 0, "R11 wake drops", det_off, 0);
    idle(2);

    // R10: sleep one cycle after auto-clear
    cyc(1, 8'h60, 0, 0);
    cyc(1, 8'h40, 0, 0);
    idle(3);
    cyc(0, 8'h00, 1, 0); settle();
    check(det_off == 0, "R10 sleep after clear", det_off, 0);

    // R11: wake wins over a qualifying sleep
    cyc(1, 8'h60, 0, 0);
    cyc(1, 8'h40, 0, 0);
    cyc(0, 8'h00, 1, 1); settle();
    check(det_off == 0, "R11 wake priority", det_off, 0);
    idle(4);

    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int r;
      bit [7:0] d;
      r = $urandom_range(0, 9);
      d = $urandom;
      if (r < 2) d[6:5] = 2'b11;
      else if (r < 4) d[6:5] = 2'b10;
      cyc(r < 6, d, ($urandom_range(0, 3) == 0), ($urandom_range(0, 7) == 0));
    end
    idle(3);
    settle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule